// File: doc/BRIEF.md
# Windowed Touch Sample FIFO

This block sits behind the touch-coordinate measurement logic. Each cycle a strobe may present a 12-bit X and a 12-bit Y coordinate. The block compares the pair against a programmable rectangle, given by an upper-right corner and a lower-left corner. A pair that lies outside the rectangle is thrown away. A pair inside it is appended to a 128-entry first-in first-out store.

The host sees the oldest stored pair at all times and removes it with a pop strobe. It also sees the current fill count and a status byte. The status byte carries overflow, full, empty and threshold-reached flags, together with a software clear bit. Two single-cycle event pulses mark the moment the fill count first reaches the programmed threshold and the moment a sample is lost to a full store. They are meant for an interrupt controller.

Configuration travels through a small write port: a 3-bit address selects a corner coordinate, the threshold or the clear bit, and a 12-bit value is written there. All state changes on the rising clock edge. Every output is driven from registers only.

Top module: `tsamp_window_fifo`

## Requirements
- R1: After reset the fill count is 0 and the status byte is 0x20. The upper-right corner is (0xFFF, 0xFFF) and the lower-left corner is (0, 0), so samples at (0xFFF, 0xFFF) and at (0, 0) are both stored.
- R2: A sample is stored only when lowX <= X <= highX and lowY <= Y <= highY, limits included. Any other sample is dropped and leaves count, data and flags untouched.
- R3: popX/popY always show the oldest stored pair. A pop strobe on a non-empty store removes that pair on the next edge. Pairs leave in arrival order.
- R4: fillCount equals the number of stored pairs, at most 128. An accepted push and a pop in the same cycle leave the count unchanged and keep the order intact.
- R5: Status bit 6 (full) is 1 exactly when the count is 128. Status bit 5 (empty) is 1 exactly when the count is 0.
- R6: An in-window sample that arrives while the count is 128 and no pop happens in that cycle is dropped, and the stored contents do not change. Status bit 7 (overflow) then sets and stays set until the software clear. oflowEvent is high for the one cycle after that edge.
- R7: Status bit 4 (threshold) is 1 when the threshold is non-zero and count >= threshold. A threshold of 0 keeps the bit at 0. thEvent is a one-cycle pulse in the first cycle in which bit 4 is 1 after a cycle in which it was 0.
- R8: Status bit 0 mirrors the clear bit. While it is 1, the store is empty, the count is 0, bits 7, 6 and 4 read 0, and samples and pops have no effect. Normal operation resumes once it is written back to 0.
- R9: A pop strobe while the store is empty has no effect on count, data or flags.
- R10: Write-port addresses are as follows. 0 is highX, 1 is highY, 2 is lowX and 3 is lowY, each taking wrData[11:0]. 4 is the threshold, taking wrData[7:0]. 5 is the clear bit, taking wrData[0]. A write takes effect on the edge at which wrEn is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A coordinate pair is presented this cycle |
| sampleX | input | 12 | X coordinate |
| sampleY | input | 12 | Y coordinate |
| popReq | input | 1 | Remove the oldest stored pair |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 3 | Configuration write address |
| wrData | input | 12 | Configuration write value |
| popX | output | 12 | X of the oldest stored pair |
| popY | output | 12 | Y of the oldest stored pair |
| fillCount | output | 8 | Number of stored pairs |
| statusByte | output | 8 | {overflow, full, empty, threshold, 3'b0, clear} |
| thEvent | output | 1 | Threshold-reached pulse |
| oflowEvent | output | 1 | Sample-lost pulse |

## Verification
A corrupted read or write pointer shows up as a wrong popX/popY on the very next cycle after the stray edge, because the head pair is compared on every cycle against a queue model. A count that drifts from the pointers shows up in fillCount and in the full and empty bits within one cycle. A wrong window comparison shows up one cycle later as a count that differs from the model. Overflow and threshold flags, and their pulses, are checked on every cycle against their defined values, so a stuck or repeated pulse is caught in the cycle where it appears.

// File: rtl/tsamp_pkg.sv
package tsamp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;

  localparam logic [2:0] ADDR_HIGH_X = 3'd0;
  localparam logic [2:0] ADDR_HIGH_Y = 3'd1;
  localparam logic [2:0] ADDR_LOW_X  = 3'd2;
  localparam logic [2:0] ADDR_LOW_Y  = 3'd3;
  localparam logic [2:0] ADDR_THRESH = 3'd4;
  localparam logic [2:0] ADDR_CLEAR  = 3'd5;
endpackage

// File: rtl/tsamp_dpath.sv
module tsamp_dpath
  import tsamp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DEPTH   = 128,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ENT_W  = 2 * COORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoCmd_t           cmd,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  output logic [COORD_W-1:0] headX,
  output logic [COORD_W-1:0] headY,
  output logic [CNT_W-1:0]   count
);
  // DEPTH must be a power of two: pointers wrap by overflow
  logic [ENT_W-1:0] memArr [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (cmd.push) memArr[wrPtr] <= {inX, inY};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= rdPtr + 1'b1;
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign {headX, headY} = memArr[rdPtr];
endmodule

// File: rtl/tsamp_ctrl.sv
module tsamp_ctrl
  import tsamp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DEPTH   = 128,
  parameter int THR_W   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [COORD_W-1:0] sampleX,
  input  logic [COORD_W-1:0] sampleY,
  input  logic               popReq,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [COORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]   count,
  output fifoCmd_t           cmd,
  output logic [7:0]         statusByte,
  output logic               thEvent,
  output logic               oflowEvent
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [COORD_W-1:0] highX, highY, lowX, lowY;
  logic [THR_W-1:0]   thresh;
  logic               clearBit, oflowFlag, thPrev;
  logic               inWin, isFull, isEmpty, sampleHit, canPop, lostSample, thTrig;

  assign inWin     = (sampleX >= lowX) && (sampleX <= highX) &&
                     (sampleY >= lowY) && (sampleY <= highY);
  assign isFull    = (count == FULL_CNT);
  assign isEmpty   = (count == '0);
  assign sampleHit = sampleValid && inWin && !clearBit;
  assign canPop    = popReq && !isEmpty && !clearBit;
  assign lostSample = sampleHit && isFull && !canPop;
  assign thTrig    = (thresh != '0) && (count >= CNT_W'(thresh));

  assign cmd.push  = sampleHit && (!isFull || canPop);
  assign cmd.pop   = canPop;
  assign cmd.clear = clearBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highX     <= '1;
      highY     <= '1;
      lowX      <= '0;
      lowY      <= '0;
      thresh    <= '0;
      clearBit  <= 1'b0;
      oflowFlag <= 1'b0;
      thPrev    <= 1'b0;
      oflowEvent <= 1'b0;
    end else begin
      thPrev     <= thTrig;
      oflowEvent <= lostSample;
      if (clearBit)        oflowFlag <= 1'b0;
      else if (lostSample) oflowFlag <= 1'b1;
      if (wrEn) begin
        case (wrAddr)
          ADDR_HIGH_X: highX    <= wrData;
          ADDR_HIGH_Y: highY    <= wrData;
          ADDR_LOW_X:  lowX     <= wrData;
          ADDR_LOW_Y:  lowY     <= wrData;
          ADDR_THRESH: thresh   <= wrData[THR_W-1:0];
          ADDR_CLEAR:  clearBit <= wrData[0];
          default: ;
        endcase
      end
    end
  end

  assign thEvent    = thTrig && !thPrev;
  assign statusByte = {oflowFlag, isFull, isEmpty, thTrig, 3'b000, clearBit};
endmodule

// File: rtl/tsamp_window_fifo.sv
module tsamp_window_fifo
  import tsamp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DEPTH   = 128,
  parameter int THR_W   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [COORD_W-1:0] sampleX,
  input  logic [COORD_W-1:0] sampleY,
  input  logic               popReq,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [COORD_W-1:0] wrData,
  output logic [COORD_W-1:0] popX,
  output logic [COORD_W-1:0] popY,
  output logic [CNT_W-1:0]   fillCount,
  output logic [7:0]         statusByte,
  output logic               thEvent,
  output logic               oflowEvent
);
  fifoCmd_t cmd;

  tsamp_ctrl #(.COORD_W(COORD_W), .DEPTH(DEPTH), .THR_W(THR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleX(sampleX),
    .sampleY(sampleY), .popReq(popReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(fillCount), .cmd(cmd), .statusByte(statusByte),
    .thEvent(thEvent), .oflowEvent(oflowEvent)
  );

  tsamp_dpath #(.COORD_W(COORD_W), .DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inX(sampleX), .inY(sampleY),
    .headX(popX), .headY(popY), .count(fillCount)
  );
endmodule

// File: rtl/tsamp_checker.sv
module tsamp_checker #(
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             popReq,
  input logic [CNT_W-1:0] fillCount,
  input logic [7:0]       statusByte,
  input logic             thEvent,
  input logic             oflowEvent
);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[6] && statusByte[5]));

  a_r5_empty_matches_count: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[5] == (fillCount == '0));

  a_r6_oflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && !statusByte[0]) |=> statusByte[7]);

  a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    oflowEvent |-> statusByte[7]);

  a_r7_event_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    thEvent |-> statusByte[4]);

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |=> (fillCount == '0));

  a_r9_pop_empty_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && popReq && !sampleValid) |=> (fillCount == '0));
endmodule

bind tsamp_window_fifo tsamp_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .popReq(popReq),
  .fillCount(fillCount), .statusByte(statusByte), .thEvent(thEvent),
  .oflowEvent(oflowEvent)
);

// File: tb/sim_tsamp_window_fifo.sv
`timescale 1ns/1ps
module sim_tsamp_window_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [11:0] sampleX = '0, sampleY = '0;
  logic popReq = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [11:0] wrData = '0;
  logic [11:0] popX, popY;
  logic [7:0] fillCount, statusByte;
  logic thEvent, oflowEvent;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsamp_window_fifo u0 (.*);

  // reference model
  logic [23:0] q[$];
  int mHiX = 4095, mHiY = 4095, mLoX = 0, mLoY = 0, mThr = 0;
  bit mClr = 0, mOflow = 0, mPrevTh = 0, mOflowEvt = 0;

  function automatic bit thOf(int c, int t);
    return (t != 0) && (c >= t);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mHiX = 4095; mHiY = 4095; mLoX = 0; mLoY = 0; mThr = 0;
      mClr = 0; mOflow = 0; mPrevTh = 0; mOflowEvt = 0;
    end else begin
      bit inW, hit, pop, wasFull;
      mPrevTh = thOf(q.size(), mThr);
      inW = (int'(sampleX) >= mLoX) && (int'(sampleX) <= mHiX) &&
            (int'(sampleY) >= mLoY) && (int'(sampleY) <= mHiY);
      hit = sampleValid && inW && !mClr;
      pop = popReq && (q.size() > 0) && !mClr;
      wasFull = (q.size() == 128);
      mOflowEvt = hit && wasFull && !pop;
      if (mClr) begin
        q.delete(); mOflow = 0;
      end else begin
        if (pop) void'(q.pop_front());
        if (hit && (!wasFull || pop)) q.push_back({sampleX, sampleY});
        if (mOflowEvt) mOflow = 1;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mHiX = wrData;
          3'd1: mHiY = wrData;
          3'd2: mLoX = wrData;
          3'd3: mLoY = wrData;
          3'd4: mThr = wrData[7:0];
          3'd5: mClr = wrData[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expStat;
      expStat = {mOflow, q.size() == 128, q.size() == 0, thOf(q.size(), mThr), 3'b000, mClr};
      chk("R4 fillCount", fillCount, q.size());
      chk("status (R5 R6 R7 R8)", statusByte, expStat);
      chk("R7 thEvent", thEvent, thOf(q.size(), mThr) && !mPrevTh);
      chk("R6 oflowEvent", oflowEvent, mOflowEvt);
      if (q.size() > 0) chk("R3 head pair", {popX, popY}, q[0]);
    end
  end

  task automatic step(bit v, int x, int y, bit p);
    sampleValid = v; sampleX = 12'(x); sampleY = 12'(y); popReq = p;
    @(negedge clk);
    sampleValid = 0; popReq = 0;
  endtask

  task automatic wr(int a, int d);
    wrEn = 1; wrAddr = 3'(a); wrData = 12'(d);
    @(negedge clk);
    wrEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset count", fillCount, 0);
    chk("R1 reset status", statusByte, 8'h20);
    step(1, 4095, 4095, 0);
    step(1, 0, 0, 0);
    chk("R1 default window accepts corners", fillCount, 2);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    // R10 + R2 window
    wr(2, 100); wr(0, 200); wr(3, 50); wr(1, 60);
    step(1, 100, 50, 0);
    step(1, 99, 55, 0);
    step(1, 201, 55, 0);
    step(1, 150, 49, 0);
    step(1, 150, 61, 0);
    step(1, 200, 60, 0);
    step(1, 150, 55, 0);
    chk("R2 inclusive window count", fillCount, 3);
    chk("R3 first pair kept", {popX, popY}, {12'd100, 12'd50});
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    chk("R9 pop on empty", fillCount, 0);
    // R7 threshold
    wr(2, 0); wr(3, 0); wr(0, 4095); wr(1, 4095);
    wr(4, 4);
    for (int i = 0; i < 5; i++) step(1, i * 17, i * 31, 0);
    chk("R7 threshold bit", statusByte[4], 1);
    // fill to full, R5
    for (int i = 5; i < 128; i++) step(1, (i * 7) % 4096, (i * 13) % 4096, 0);
    chk("R5 full", statusByte[6], 1);
    // R6 overflow
    step(1, 1, 2, 0);
    step(1, 3, 4, 0);
    chk("R6 overflow flag", statusByte[7], 1);
    // R4 push and pop together while full
    step(1, 77, 88, 1);
    chk("R4 simultaneous keeps count", fillCount, 128);
    for (int i = 0; i < 70; i++) step(i % 2, i + 300, i + 400, 1);
    chk("R6 overflow sticky", statusByte[7], 1);
    // R7 threshold zero disables
    wr(4, 0);
    chk("R7 zero threshold", statusByte[4], 0);
    wr(4, 200);
    chk("R7 above count", statusByte[4], 0);
    // R8 clear
    wr(5, 1);
    step(1, 5, 5, 1);
    chk("R8 cleared count", fillCount, 0);
    chk("R8 cleared status", statusByte, 8'h21);
    wr(5, 0);
    wr(4, 1);
    step(1, 9, 10, 0);
    chk("R8 resumes", fillCount, 1);
    step(0, 0, 0, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule